// File: doc/BRIEF.md
# HDLC Channel Status and Event Register

This block collects status for one HDLC channel and presents it as a single 8-bit word on a small register read port. It takes event pulses from the receive engine (frame good, CRC fault, overrun, abort, opening byte) and from the transmit engine (message sent). It also takes a level from a bit-oriented-code detector. Alongside these inputs it watches the byte counts of a receive FIFO and a transmit FIFO, both `DEPTH` bytes deep.

Four of the status bits record events. Each stays set until software reads the status word, and that read clears it. The other four bits are live FIFO-level conditions, refreshed every clock. A combined interrupt line is high while any recorded event is pending. A two-bit control register lets software turn off zero-bit insertion and CRC generation on the transmit side.

Register port: address 0 is the status word, which is read-only; reads of it clear the recorded events. Address 1 is the control register, which can be written and read. Read data appears on `rd_data` one clock after `rd_en` and holds until the next read.

Top module: `hdlc_stat_reg`

## Requirements
- R1: The status word at address 0 is laid out as follows. Bit 7 is code-detector change, bit 6 is packet end, bit 5 is packet start, bit 4 is receive half full, bit 3 is receive not empty, bit 2 is transmit half empty, bit 1 is transmit not full and bit 0 is transmit message end. A read registers the word on `rd_data` at the clock edge where `rd_en` is sampled.
- R2: Bit 7 is recorded when `boc_valid` goes from 0 to 1 and when it goes from 1 to 0. A steady level records nothing. After reset the detector is taken to be in the no-code state (0).
- R3: Bit 6 is recorded by any one of four pulses: `rx_frame_ok`, `rx_crc_err`, `rx_overrun` or `rx_abort`.
- R4: Bit 5 is recorded by an `rx_open` pulse.
- R5: Bit 4 reads 1 exactly when `rx_fill` > DEPTH/2. Bit 3 reads 1 exactly when `rx_fill` ≥ 1. Both show the fill sampled one clock earlier.
- R6: Bit 2 reads 1 exactly when `tx_fill` < DEPTH/2. Bit 1 reads 1 exactly when `tx_fill` < DEPTH. Both show the fill sampled one clock earlier.
- R7: Bit 0 is recorded by a `tx_msg_done` pulse.
- R8: A recorded bit stays 1 until a status read. That read returns 1 for the bit and clears it at the same edge. The live bits 4..1 are not affected by reads.
- R9: If an event arrives in the same cycle as a status read, that read returns the old value, and the bit is still 1 afterwards.
- R10: A write to address 1 loads `wr_data` into the control register. Bit 1 drives `ctl_no_stuff` and bit 0 drives `ctl_no_crc`. A read of address 1 returns the register in bits 1:0 with zeros above. A write to address 0 changes nothing.
- R11: `irq` is 1 exactly while at least one recorded bit (7, 6, 5, 0) is 1.
- R12: Synchronous reset clears the recorded bits, the control register, `rd_data` and `irq`.
- R13: `rd_data` keeps its value in every cycle without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 1 | Read address: 0 status, 1 control |
| rd_data | output | 8 | Registered read data |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | Write address: only 1 (control) takes effect |
| wr_data | input | CTL_W (2) | Control write data |
| boc_valid | input | 1 | Code detector level: 1 while a valid code is seen |
| rx_frame_ok | input | 1 | Pulse: frame completed with good CRC |
| rx_crc_err | input | 1 | Pulse: CRC check failed |
| rx_overrun | input | 1 | Pulse: receive overrun |
| rx_abort | input | 1 | Pulse: abort received |
| rx_open | input | 1 | Pulse: opening byte detected |
| tx_msg_done | input | 1 | Pulse: transmit message finished |
| rx_fill | input | FILL_W (7) | Bytes held in the receive FIFO |
| tx_fill | input | FILL_W (7) | Bytes held in the transmit FIFO |
| irq | output | 1 | High while any recorded event is pending |
| ctl_no_stuff | output | 1 | 1 turns off transmit zero insertion |
| ctl_no_crc | output | 1 | 1 turns off transmit CRC generation |

## Verification
The clearing read and the arrival of a new event are the two functions that can land in the same cycle. The bench raises `rx_open` in the same clock in which it strobes a status read. It expects that read to show bit 5 clear, because the value is taken from before the edge. It expects the next read to show bit 5 set. The same race is covered continuously by the property that any event forces its bit high at the following edge, whatever the read does.

// File: rtl/hdlc_stat_pkg.sv
package hdlc_stat_pkg;
  // Status word bit positions (software decodes these)
  localparam int unsigned P_BOC_CHG  = 7;
  localparam int unsigned P_PKT_END  = 6;
  localparam int unsigned P_PKT_OPEN = 5;
  localparam int unsigned P_RX_HALF  = 4;
  localparam int unsigned P_RX_NE    = 3;
  localparam int unsigned P_TX_HALFE = 2;
  localparam int unsigned P_TX_NF    = 1;
  localparam int unsigned P_TX_END   = 0;

  // Index of each recorded event inside the sticky vector
  localparam int unsigned NUM_EV  = 4;
  localparam int unsigned E_TXEND = 0;
  localparam int unsigned E_OPEN  = 1;
  localparam int unsigned E_END   = 2;
  localparam int unsigned E_BOC   = 3;

  localparam logic ADDR_STAT = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;
endpackage

// File: rtl/hdlc_stat_sticky.sv
module hdlc_stat_sticky #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= set[i] | (q[i] & ~clr);
    end

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> q[i]);                                   // R9
    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
      (clr && !set[i]) |=> !q[i]);                        // R8
    AST_HOLD_UNTIL_READ: assert property (@(posedge clk) disable iff (rst)
      (q[i] && !clr) |=> q[i]);                           // R8
  end
endmodule

// File: rtl/hdlc_stat_level.sv
module hdlc_stat_level #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FILL_W-1:0] rx_fill,
  input  logic [FILL_W-1:0] tx_fill,
  output logic              rx_half,
  output logic              rx_ne,
  output logic              tx_half_empty,
  output logic              tx_nf
);
  localparam logic [FILL_W-1:0] HALF = FILL_W'(DEPTH / 2);
  localparam logic [FILL_W-1:0] FULL = FILL_W'(DEPTH);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_half       <= 1'b0;
      rx_ne         <= 1'b0;
      tx_half_empty <= 1'b0;
      tx_nf         <= 1'b0;
    end else begin
      rx_half       <= rx_fill > HALF;
      rx_ne         <= rx_fill != '0;
      tx_half_empty <= tx_fill < HALF;
      tx_nf         <= tx_fill < FULL;
    end
  end

  AST_HALF_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    rx_half |-> rx_ne);                                   // R5
  AST_HALF_EMPTY_NOT_FULL: assert property (@(posedge clk) disable iff (rst)
    tx_half_empty |-> tx_nf);                             // R6
endmodule

// File: rtl/hdlc_stat_ctrl.sv
module hdlc_stat_ctrl #(
  parameter int unsigned CTL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [CTL_W-1:0] wr_data,
  output logic [CTL_W-1:0] ctl
);
  import hdlc_stat_pkg::*;

  logic hit;
  assign hit = wr_en && (wr_addr == ADDR_CTRL);

  always_ff @(posedge clk) begin
    if (rst)      ctl <= '0;
    else if (hit) ctl <= wr_data;
  end

  AST_CTRL_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(ctl));                               // R10
endmodule

// File: rtl/hdlc_stat_reg.sv
module hdlc_stat_reg #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned FILL_W = $clog2(DEPTH + 1),
  parameter int unsigned CTL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              rd_addr,
  output logic [7:0]        rd_data,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [CTL_W-1:0]  wr_data,
  input  logic              boc_valid,
  input  logic              rx_frame_ok,
  input  logic              rx_crc_err,
  input  logic              rx_overrun,
  input  logic              rx_abort,
  input  logic              rx_open,
  input  logic              tx_msg_done,
  input  logic [FILL_W-1:0] rx_fill,
  input  logic [FILL_W-1:0] tx_fill,
  output logic              irq,
  output logic              ctl_no_stuff,
  output logic              ctl_no_crc
);
  import hdlc_stat_pkg::*;

  logic              boc_q;
  logic [NUM_EV-1:0] ev;
  logic [NUM_EV-1:0] held;
  logic              stat_rd;
  logic              lv_rx_half, lv_rx_ne, lv_tx_halfe, lv_tx_nf;
  logic [CTL_W-1:0]  ctl;
  logic [7:0]        stat_word;

  // Code-detector edge tracking; reset state is "no code"
  always_ff @(posedge clk) begin
    if (rst) boc_q <= 1'b0;
    else     boc_q <= boc_valid;
  end

  always_comb begin
    ev          = '0;
    ev[E_BOC]   = boc_valid ^ boc_q;
    ev[E_END]   = rx_frame_ok | rx_crc_err | rx_overrun | rx_abort;
    ev[E_OPEN]  = rx_open;
    ev[E_TXEND] = tx_msg_done;
  end

  assign stat_rd = rd_en && (rd_addr == ADDR_STAT);

  hdlc_stat_sticky #(.N(NUM_EV)) u_sticky (
    .clk (clk),
    .rst (rst),
    .clr (stat_rd),
    .set (ev),
    .q   (held)
  );

  hdlc_stat_level #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_level (
    .clk           (clk),
    .rst           (rst),
    .rx_fill       (rx_fill),
    .tx_fill       (tx_fill),
    .rx_half       (lv_rx_half),
    .rx_ne         (lv_rx_ne),
    .tx_half_empty (lv_tx_halfe),
    .tx_nf         (lv_tx_nf)
  );

  hdlc_stat_ctrl #(.CTL_W(CTL_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ctl     (ctl)
  );

  always_comb begin
    stat_word             = '0;
    stat_word[P_BOC_CHG]  = held[E_BOC];
    stat_word[P_PKT_END]  = held[E_END];
    stat_word[P_PKT_OPEN] = held[E_OPEN];
    stat_word[P_RX_HALF]  = lv_rx_half;
    stat_word[P_RX_NE]    = lv_rx_ne;
    stat_word[P_TX_HALFE] = lv_tx_halfe;
    stat_word[P_TX_NF]    = lv_tx_nf;
    stat_word[P_TX_END]   = held[E_TXEND];
  end

  always_ff @(posedge clk) begin
    if (rst)             rd_data <= '0;
    else if (rd_en) begin
      if (stat_rd)       rd_data <= stat_word;
      else               rd_data <= 8'(ctl);
    end
  end

  assign irq          = |held;
  assign ctl_no_stuff = ctl[1];
  assign ctl_no_crc   = ctl[0];

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));                         // R13
  AST_IRQ_DROPS_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && ev == '0) |=> !irq);                      // R11
  AST_BOC_STEADY_QUIET: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && $stable(boc_valid) && boc_valid == boc_q) |=> !held[E_BOC]); // R2
endmodule

// File: tb/hdlc_stat_reg_bench.sv
module hdlc_stat_reg_bench;
  localparam int DEPTH  = 64;
  localparam int FILL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_en = 0, rd_addr = 0, wr_en = 0, wr_addr = 0;
  logic [1:0] wr_data = '0;
  logic boc_valid = 0, rx_frame_ok = 0, rx_crc_err = 0, rx_overrun = 0;
  logic rx_abort = 0, rx_open = 0, tx_msg_done = 0;
  logic [FILL_W-1:0] rx_fill = '0, tx_fill = '0;
  logic [7:0] rd_data;
  logic irq, ctl_no_stuff, ctl_no_crc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hdlc_stat_reg u_hdlc_stat_reg (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .boc_valid(boc_valid),
    .rx_frame_ok(rx_frame_ok), .rx_crc_err(rx_crc_err), .rx_overrun(rx_overrun),
    .rx_abort(rx_abort), .rx_open(rx_open), .tx_msg_done(tx_msg_done),
    .rx_fill(rx_fill), .tx_fill(tx_fill), .irq(irq),
    .ctl_no_stuff(ctl_no_stuff), .ctl_no_crc(ctl_no_crc)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] live(input int rx, input int tx);
    logic [7:0] w = '0;
    w[4] = rx > DEPTH / 2;
    w[3] = rx >= 1;
    w[2] = tx < DEPTH / 2;
    w[1] = tx < DEPTH;
    return w;
  endfunction

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic wr(input logic a, input logic [1:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: rx_frame_ok = 1; 1: rx_crc_err = 1; 2: rx_overrun = 1;
      3: rx_abort = 1;    4: rx_open = 1;    default: tx_msg_done = 1;
    endcase
    @(negedge clk);
    {rx_frame_ok, rx_crc_err, rx_overrun, rx_abort, rx_open, tx_msg_done} = '0;
  endtask

  task automatic finish_up();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  initial begin
    logic [7:0] d, base;
    repeat (3) @(negedge clk);
    chk("R12 rd_data in reset", rd_data, 8'h00);
    chk("R12 irq in reset", {7'b0, irq}, 8'h00);
    @(negedge clk); rst = 0;

    // Live bit sweeps
    for (int v = 0; v <= DEPTH; v++) begin
      @(negedge clk); rx_fill = FILL_W'(v); tx_fill = '0;
      rd(1'b0, d);
      chk($sformatf("R5 R1 rx_fill=%0d", v), d, live(v, 0));
    end
    for (int v = 0; v <= DEPTH; v++) begin
      @(negedge clk); tx_fill = FILL_W'(v); rx_fill = '0;
      rd(1'b0, d);
      chk($sformatf("R6 R1 tx_fill=%0d", v), d, live(0, v));
    end

    @(negedge clk); rx_fill = 7'd40; tx_fill = 7'd20;
    base = live(40, 20);

    // Packet end sources, packet start, message end
    for (int k = 0; k < 6; k++) begin
      logic [7:0] bitv;
      bitv = (k < 4) ? 8'h40 : (k == 4) ? 8'h20 : 8'h01;
      pulse(k);
      chk($sformatf("R11 irq after event %0d", k), {7'b0, irq}, 8'h01);
      pulse(k);
      rd(1'b0, d);
      chk($sformatf("%s event %0d recorded", k < 4 ? "R3" : k == 4 ? "R4" : "R7", k),
          d, base | bitv);
      chk("R11 irq cleared by read", {7'b0, irq}, 8'h00);
      rd(1'b0, d);
      chk("R8 cleared after read, live kept", d, base);
    end

    // Hold until read across idle cycles
    pulse(5);
    repeat (5) @(negedge clk);
    rd(1'b0, d);
    chk("R8 bit held across idle cycles", d, base | 8'h01);

    // Code detector edges
    @(negedge clk); boc_valid = 1;
    rd(1'b0, d);
    chk("R2 rise recorded", d, base | 8'h80);
    repeat (4) @(negedge clk);
    rd(1'b0, d);
    chk("R2 steady level records nothing", d, base);
    @(negedge clk); boc_valid = 0;
    rd(1'b0, d);
    chk("R2 fall recorded", d, base | 8'h80);

    // Collision of event with clearing read
    @(negedge clk); rx_open = 1; rd_en = 1; rd_addr = 1'b0;
    @(negedge clk); rx_open = 0; rd_en = 0; d = rd_data;
    chk("R9 colliding read shows old value", d, base);
    chk("R9 irq still set", {7'b0, irq}, 8'h01);
    rd(1'b0, d);
    chk("R9 event survives colliding read", d, base | 8'h20);

    // Control register
    rd(1'b1, d);
    chk("R12 control after reset", d, 8'h00);
    wr(1'b1, 2'b11);
    rd(1'b1, d);
    chk("R10 control readback 3", d, 8'h03);
    chk("R10 outputs 11", {6'b0, ctl_no_stuff, ctl_no_crc}, 8'h03);
    wr(1'b1, 2'b10);
    chk("R10 outputs 10", {6'b0, ctl_no_stuff, ctl_no_crc}, 8'h02);
    wr(1'b0, 2'b01);
    rd(1'b1, d);
    chk("R10 write to status address ignored", d, 8'h02);

    // Read data hold
    rd(1'b0, d);
    @(negedge clk); rx_fill = '0; tx_fill = 7'd64; pulse(4);
    repeat (3) @(negedge clk);
    chk("R13 rd_data held without read", rd_data, d);

    // Reset mid-run
    pulse(1);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R12 irq after reset", {7'b0, irq}, 8'h00);
    chk("R12 control after reset", {6'b0, ctl_no_stuff, ctl_no_crc}, 8'h00);
    chk("R12 rd_data after reset", rd_data, 8'h00);
    rd(1'b0, d);
    chk("R12 events cleared by reset", d, live(0, 64));

    finish_up();
  end
endmodule